// File: doc/BRIEF.md
# Console Cartridge Bank Mapper

This block stands in for a game cartridge on a small 8-bit console. The console sees a 4 KB window through a 12-bit address and an 8-bit data path. Behind the window sits a larger program image split into 4 KB banks. One bank is visible at a time. Reading one of a short run of reserved addresses near the top of the window picks the visible bank. No data is written to change the bank.

The cartridge also carries 256 bytes of RAM. The console has no read/write line, so the RAM uses two address windows. Any access to the lowest 256 offsets of the window stores the byte present on the data input. Any access to the next 256 offsets returns the stored byte.

Every access is answered combinationally within the same bus cycle. Side effects take place on the rising clock edge that ends the cycle: a bank change or a RAM store. The console gives no reset, so the bank register takes its value from configuration alone. The program image is generated from a formula set by a seed parameter.

Top module: `cart_bank_mapper`

## Requirements
- R1: With no reset applied, the visible bank after configuration is the last bank (bank 7 with the default 8 banks).
- R2: A selected access to a ROM offset (0x200 to 0xFFF) drives `dout_oe` high. It returns image byte `a[7:0] + 29*a[15:8] + SEED` (modulo 256), where `a = bank*4096 + offset`.
- R3: The hotspots are offsets `0x1000 - 4 - BANKS + k`, which is 0xFF4 to 0xFFB for 8 banks. A selected access to a hotspot returns the byte of the bank that was visible before the access. From the next cycle on, bank k is visible.
- R4: While `cs` is low, `dout_oe` is low and `dout` is 0x00. The access changes neither the bank nor the RAM.
- R5: A selected access to offsets 0x000 to 0x0FF leaves `dout_oe` low and `dout` at 0x00. It stores `din` into RAM byte `offset[7:0]` at the end of the cycle.
- R6: A selected access to offsets 0x100 to 0x1FF drives `dout_oe` high and returns RAM byte `offset[7:0]`.
- R7: A RAM store leaves the visible bank unchanged. A bank change leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock; side effects take place on its rising edge |
| cs | input | 1 | Cartridge select, high when the access targets the cartridge window |
| addr | input | 12 | Offset within the 4 KB cartridge window |
| din | input | 8 | Data bus value seen by the cartridge, stored on RAM write-window accesses |
| dout | output | 8 | Data returned to the console; 0x00 when not driving |
| dout_oe | output | 1 | High when the cartridge drives the data bus |

## Verification
A wrong bank register shows up at the first ROM read after the fault. Every image byte carries its bank number in the formula, so the value on `dout` is wrong at once. A missed or misdirected RAM store only appears when that byte is read back through the read window. The sweep therefore fills every RAM byte before reading any of them. A decoder that confuses the windows shows up in the same cycle as a wrong `dout_oe`. Hotspot ordering errors, where the new bank is returned too early, show up on the hotspot access itself.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int          BANKS    = 8,
  parameter int          WIN_AW   = 12,
  parameter int          RAM_AW   = 8,
  parameter logic [7:0]  ROM_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              cs,
  input  logic [WIN_AW-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  localparam int BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int IMG_AW    = WIN_AW + BANK_W;
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam logic [WIN_AW-1:0] HOT_LO = WIN_AW'((1 << WIN_AW) - 4 - BANKS);

  logic [BANK_W-1:0] bank = BANK_W'(BANKS - 1);
  logic [7:0]        ram [RAM_DEPTH];

  logic              wr_win, rd_win, rom_area, hot;
  logic [WIN_AW-1:0] hot_off;
  logic [IMG_AW-1:0] img_addr;
  logic [7:0]        rom_byte, ram_q;

  assign wr_win   = (addr[WIN_AW-1:RAM_AW] == '0);
  assign rd_win   = (addr[WIN_AW-1:RAM_AW] == (WIN_AW-RAM_AW)'(1));
  assign rom_area = !wr_win && !rd_win;
  assign hot_off  = addr - HOT_LO;
  assign hot      = rom_area && (hot_off < WIN_AW'(BANKS));

  assign img_addr = {bank, addr};
  assign rom_byte = img_addr[7:0] + 8'(img_addr[IMG_AW-1:8]) * 8'd29 + ROM_SEED;
  assign ram_q    = ram[addr[RAM_AW-1:0]];

  assign dout_oe  = cs && !wr_win;
  assign dout     = !dout_oe ? 8'h00 : (rd_win ? ram_q : rom_byte);

  always_ff @(posedge clk) begin
    if (cs && hot)
      bank <= BANK_W'(hot_off);
    if (cs && wr_win)
      ram[addr[RAM_AW-1:0]] <= din;
  end
endmodule

module cart_bank_mapper_chk #(
  parameter int BANKS  = 8,
  parameter int WIN_AW = 12,
  parameter int RAM_AW = 8,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              cs,
  input logic [WIN_AW-1:0] addr,
  input logic              dout_oe,
  input logic [BANK_W-1:0] bank
);
  localparam logic [WIN_AW-1:0] HOT_LO = WIN_AW'((1 << WIN_AW) - 4 - BANKS);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  a_r1_config_bank: assert property (@(posedge clk)
    !started |-> bank == BANK_W'(BANKS - 1));
  a_r4_no_drive_unselected: assert property (@(posedge clk) disable iff (!started)
    !cs |-> !dout_oe);
  a_r4_bank_held_unselected: assert property (@(posedge clk) disable iff (!started)
    !cs |=> $stable(bank));
  a_r5_write_window_undriven: assert property (@(posedge clk) disable iff (!started)
    (cs && addr < WIN_AW'(1 << RAM_AW)) |-> !dout_oe);
  a_r6_read_window_driven: assert property (@(posedge clk) disable iff (!started)
    (cs && addr >= WIN_AW'(1 << RAM_AW) && addr < WIN_AW'(2 << RAM_AW)) |-> dout_oe);
  a_r3_hotspot_selects: assert property (@(posedge clk) disable iff (!started)
    (cs && addr >= HOT_LO && addr < HOT_LO + WIN_AW'(BANKS)) |=>
      bank == BANK_W'($past(addr) - HOT_LO));
  a_r7_write_keeps_bank: assert property (@(posedge clk) disable iff (!started)
    (cs && addr < WIN_AW'(1 << RAM_AW)) |=> $stable(bank));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .BANKS(BANKS), .WIN_AW(WIN_AW), .RAM_AW(RAM_AW), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .cs(cs), .addr(addr), .dout_oe(dout_oe), .bank(bank)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  localparam logic [7:0] SEED = 8'h5A;
  localparam int HOT = 12'hFF4;

  logic clk = 1'b0;
  logic cs = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cart_bank_mapper #(.ROM_SEED(SEED)) u_dut (
    .clk(clk), .cs(cs), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [7:0] rom_val(input int b, input int off);
    int a = b * 4096 + off;
    return 8'((a & 255) + 29 * (a >> 8) + int'(SEED));
  endfunction

  task automatic access(input int a, input logic [7:0] d, input logic c);
    @(negedge clk);
    addr = 12'(a); din = d; cs = c;
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] exp_d, input logic exp_oe);
    checks++;
    if (dout !== exp_d || dout_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s addr=%h: dout=%h oe=%b expected dout=%h oe=%b",
               req, addr, dout, dout_oe, exp_d, exp_oe);
    end
  endtask

  initial begin
    int prev;
    access(12'h800, 8'h00, 1'b1);
    chk("R1", rom_val(7, 12'h800), 1'b1);

    access(HOT, 8'h00, 1'b0);
    chk("R4", 8'h00, 1'b0);
    access(12'h900, 8'h00, 1'b1);
    chk("R4", rom_val(7, 12'h900), 1'b1);

    prev = 7;
    for (int k = 0; k < 8; k++) begin
      access(HOT + k, 8'h00, 1'b1);
      chk("R3", rom_val(prev, HOT + k), 1'b1);
      prev = k;
      for (int off = 12'h200; off < 4096; off++) begin
        if (off >= HOT && off < HOT + 8) continue;
        access(off, 8'h00, 1'b1);
        chk("R2", rom_val(k, off), 1'b1);
      end
    end

    for (int i = 0; i < 256; i++) begin
      access(i, 8'(i * 3 + 1), 1'b1);
      chk("R5", 8'h00, 1'b0);
    end
    for (int i = 0; i < 256; i++) begin
      access(12'h100 + i, 8'h00, 1'b1);
      chk("R6", 8'(i * 3 + 1), 1'b1);
    end
    access(12'h900, 8'h00, 1'b1);
    chk("R7", rom_val(7, 12'h900), 1'b1);

    access(HOT + 2, 8'h00, 1'b1);
    chk("R3", rom_val(7, HOT + 2), 1'b1);
    access(12'h105, 8'h00, 1'b1);
    chk("R7", 8'(5 * 3 + 1), 1'b1);
    access(12'hA00, 8'h00, 1'b1);
    chk("R3", rom_val(2, 12'hA00), 1'b1);

    access(12'h005, 8'hEE, 1'b0);
    chk("R4", 8'h00, 1'b0);
    access(12'h105, 8'h00, 1'b1);
    chk("R4", 8'(5 * 3 + 1), 1'b1);

    access(12'h005, 8'hC3, 1'b1);
    chk("R5", 8'h00, 1'b0);
    access(12'h105, 8'h00, 1'b1);
    chk("R5", 8'hC3, 1'b1);
    access(12'hFFF, 8'h00, 1'b1);
    chk("R2", rom_val(2, 12'hFFF), 1'b1);
    access(12'hA00, 8'h00, 1'b1);
    chk("R3", rom_val(2, 12'hA00), 1'b1);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule